// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller with Return Stack

This block sits beside a small processor core and decides when a pending interrupt is taken. It keeps a 4-bit enable register and a 4-bit request register. Bit 0 of each belongs to the timer source and bit 1 to the port source. Bits 3 and 2 always read as zero.

The block does not take an interrupt as soon as one becomes ready. It counts instructions and takes the interrupt only after two more have completed. If either of those instructions withdraws the enable or the request, the interrupt is dropped. When an interrupt is taken, the block raises an accept strobe together with a fixed vector address. It also clears every enable flag and pushes the core's program counter and carry flag onto its own 4-entry return stack.

The core also uses that stack for subroutine calls. It pops the stack for both kinds of return: one kind restores the carry flag and the other leaves it unchanged.

Top module: `intc_core`

## Requirements
- R1: After a synchronous reset, `ie_q` and `irq_q` are 0, `irq_take`, `push_req` and `ret_valid` are 0, and `irq_vec` is 000h.
- R2: A register write with `wr_sel`=0 loads the enable register and with `wr_sel`=1 loads the request register. Bit 0 is the timer source and bit 1 the port source. Bits 3:2 of both registers always read 0. The written value is visible on the cycle after the write.
- R3: `tmr_evt` sets request bit 0 and `port_evt` sets request bit 1. A hardware set wins over a software write of 0 to the same bit in the same cycle.
- R4: An interrupt can be taken only for a source whose request bit and enable bit are both 1.
- R5: An `instr_done` pulse counts only in a cycle where `ie_q & irq_q` has a bit set in positions 1:0. The clock edge that ends the second counted pulse loads a count of 2. The next edge accepts the interrupt. `irq_take` is high for exactly the one cycle after that accepting edge.
- R6: Any cycle in which no enabled request is visible resets the instruction count. So if either of the two counted instructions clears the enable or the request, no interrupt is taken, and counting starts again from zero.
- R7: The vector is 002h for the timer and 004h for the port. The timer wins when both are pending. `irq_vec` holds its value until the next accept.
- R8: The accepting edge clears every enable bit, overriding a same-cycle enable write. The request bits are left unchanged.
- R9: The accepting edge, or a `call_push`, pushes one 13-bit entry holding `cur_cy` as the most significant bit above `cur_pc`. `push_req` is high for the cycle after every push. An accept and a call in the same cycle make a single push.
- R10: `ret_pop` pops the newest entry: `ret_valid` is high for the following cycle, showing `ret_pc` and `ret_cy`. `ret_cy_ld` is 1 when `ret_cy_mode`=1 (the interrupt return restores the carry flag) and 0 when `ret_cy_mode`=0 (the constant return leaves the carry flag unchanged). A pop in the same cycle as a push is ignored.
- R11: The stack holds 4 entries. A fifth push drops the oldest entry, so four pops after five pushes return pushes 5, 4, 3 and 2 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | One instruction completes this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the enable register, 1 the request register |
| wr_data | input | 4 | Write data |
| tmr_evt | input | 1 | Timer source raises its request |
| port_evt | input | 1 | Port source raises its request |
| cur_pc | input | 12 | Core program counter to save |
| cur_cy | input | 1 | Core carry flag to save |
| call_push | input | 1 | Subroutine call pushes the stack |
| ret_pop | input | 1 | Return pops the stack |
| ret_cy_mode | input | 1 | 1 restores the carry flag on this return |
| ie_q | output | 4 | Enable register read value |
| irq_q | output | 4 | Request register read value |
| irq_take | output | 1 | Interrupt accepted strobe |
| irq_vec | output | 12 | Vector address of the last accept |
| push_req | output | 1 | A stack push took place on the previous edge |
| ret_valid | output | 1 | Popped entry is valid this cycle |
| ret_pc | output | 12 | Popped program counter |
| ret_cy | output | 1 | Popped carry flag |
| ret_cy_ld | output | 1 | Core should load `ret_cy` into its carry flag |

## Verification
The hardest case to produce is a cancellation in the middle of the two-instruction window. The pending condition has to go away on exactly the first or the second counted instruction, and it may then come back at once. Random traffic rarely lines this up, so directed sequences build each variant: enable then clear on I1, enable then clear on I2, and clear then re-set in back-to-back instructions. A cycle-level reference model in the bench then follows the same window through several thousand random cycles of writes, events and idle gaps.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int PC_W   = 12;
  localparam int REG_W  = 4;
  localparam int NSRC   = 2;
  localparam int SRC_TMR  = 0;
  localparam int SRC_PORT = 1;
  localparam logic [PC_W-1:0] VEC_RESET = '0;
  localparam int VEC_STEP = 2;   // source i vectors to (i+1)*VEC_STEP

  typedef struct packed {
    logic            cy;
    logic [PC_W-1:0] pc;
  } stk_ent_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs #(
  parameter int REG_W = 4,
  parameter int NSRC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NSRC-1:0]  hw_set,
  input  logic             take,
  output logic [REG_W-1:0] ie_q,
  output logic [REG_W-1:0] irq_q
);
  logic [NSRC-1:0] ie_r, rq_r;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        ie_r[i] <= 1'b0;
        rq_r[i] <= 1'b0;
      end else begin
        if (take)
          ie_r[i] <= 1'b0;
        else if (wr_en && !wr_sel)
          ie_r[i] <= wr_data[i];
        if (hw_set[i])
          rq_r[i] <= 1'b1;
        else if (wr_en && wr_sel)
          rq_r[i] <= wr_data[i];
      end
    end

    // R3: a hardware set is never lost to a same-cycle software clear
    a_r3_hw_set_wins: assert property (@(posedge clk) disable iff (rst)
      $past(hw_set[i]) && !$past(rst) |-> irq_q[i]);
  end

  if (REG_W > NSRC) begin : g_pad
    assign ie_q  = {{(REG_W-NSRC){1'b0}}, ie_r};
    assign irq_q = {{(REG_W-NSRC){1'b0}}, rq_r};
  end else begin : g_nopad
    assign ie_q  = ie_r;
    assign irq_q = rq_r;
  end

  // R8: an accept leaves every enable cleared
  a_r8_take_clears_en: assert property (@(posedge clk) disable iff (rst)
    $past(take) && !$past(rst) |-> ie_q == '0);
endmodule

// File: rtl/intc_sched.sv
module intc_sched
  import intc_pkg::*;
#(
  parameter int NSRC  = 2,
  parameter int DELAY = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_done,
  input  logic [NSRC-1:0] ie,
  input  logic [NSRC-1:0] rq,
  output logic            take,
  output logic            take_q,
  output logic [PC_W-1:0] vec_q
);
  localparam int CW = $clog2(DELAY + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DELAY);

  logic [NSRC-1:0] hit;
  logic            pend;
  logic [CW-1:0]   cnt;
  logic [PC_W-1:0] vec_next;

  assign hit  = ie & rq;
  assign pend = |hit;
  assign take = pend && (cnt == CNT_MAX);

  // lowest index has priority
  always_comb begin
    vec_next = VEC_RESET;
    for (int i = NSRC - 1; i >= 0; i--)
      if (hit[i]) vec_next = PC_W'((i + 1) * VEC_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      take_q <= 1'b0;
      vec_q  <= VEC_RESET;
    end else begin
      take_q <= take;
      if (take) vec_q <= vec_next;
      if (take || !pend)
        cnt <= '0;
      else if (instr_done && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX);
  // R5: an accept strobe follows a full count
  a_r5_take_after_count: assert property (@(posedge clk) disable iff (rst)
    take_q && !$past(rst) |-> $past(cnt) == CNT_MAX);
  // R4: only an enabled, requested source is taken
  a_r4_take_needs_hit: assert property (@(posedge clk) disable iff (rst)
    take_q && !$past(rst) |-> $past(ie & rq) != '0);
endmodule

// File: rtl/intc_stack.sv
module intc_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         pop_mode,
  input  logic [W-1:0] din,
  output logic         push_q,
  output logic         ret_valid,
  output logic         ret_cy_ld,
  output logic [W-1:0] ret_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] sp;
  logic [AW-1:0] sp_inc;
  logic          do_pop;

  assign sp_inc = sp + 1'b1;      // wraps: the oldest entry is overwritten
  assign do_pop = pop && !push;

  always_ff @(posedge clk) begin
    if (push) mem[sp_inc] <= din;
    if (do_pop) ret_data <= mem[sp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp        <= '0;
      push_q    <= 1'b0;
      ret_valid <= 1'b0;
      ret_cy_ld <= 1'b0;
    end else begin
      push_q    <= push;
      ret_valid <= do_pop;
      if (do_pop) ret_cy_ld <= pop_mode;
      if (push)
        sp <= sp_inc;
      else if (pop)
        sp <= sp - 1'b1;
    end
  end

  // R10: a pop result is never shown in the cycle after a push edge
  a_r10_pop_excl_push: assert property (@(posedge clk) disable iff (rst)
    push_q |-> !ret_valid);
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        instr_done,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [3:0]  wr_data,
  input  logic        tmr_evt,
  input  logic        port_evt,
  input  logic [11:0] cur_pc,
  input  logic        cur_cy,
  input  logic        call_push,
  input  logic        ret_pop,
  input  logic        ret_cy_mode,
  output logic [3:0]  ie_q,
  output logic [3:0]  irq_q,
  output logic        irq_take,
  output logic [11:0] irq_vec,
  output logic        push_req,
  output logic        ret_valid,
  output logic [11:0] ret_pc,
  output logic        ret_cy,
  output logic        ret_cy_ld
);
  localparam int DEPTH = 4;
  localparam int DELAY = 2;
  localparam int ENT_W = $bits(stk_ent_t);

  logic            take;
  logic [NSRC-1:0] hw_set;
  stk_ent_t        push_ent, pop_ent;
  logic [ENT_W-1:0] pop_raw;

  always_comb begin
    hw_set           = '0;
    hw_set[SRC_TMR]  = tmr_evt;
    hw_set[SRC_PORT] = port_evt;
  end

  intc_regs #(.REG_W(REG_W), .NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hw_set(hw_set), .take(take), .ie_q(ie_q), .irq_q(irq_q)
  );

  intc_sched #(.NSRC(NSRC), .DELAY(DELAY)) u_sched (
    .clk(clk), .rst(rst), .instr_done(instr_done),
    .ie(ie_q[NSRC-1:0]), .rq(irq_q[NSRC-1:0]),
    .take(take), .take_q(irq_take), .vec_q(irq_vec)
  );

  assign push_ent.cy = cur_cy;
  assign push_ent.pc = cur_pc;

  intc_stack #(.DEPTH(DEPTH), .W(ENT_W)) u_stack (
    .clk(clk), .rst(rst), .push(take || call_push), .pop(ret_pop),
    .pop_mode(ret_cy_mode), .din(push_ent), .push_q(push_req),
    .ret_valid(ret_valid), .ret_cy_ld(ret_cy_ld), .ret_data(pop_raw)
  );

  assign pop_ent = stk_ent_t'(pop_raw);
  assign ret_pc  = pop_ent.pc;
  assign ret_cy  = pop_ent.cy;

  // R9: every accept is accompanied by a push
  a_r9_take_pushes: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> push_req);
  // R7: timer wins the vector when it was pending
  a_r7_timer_first: assert property (@(posedge clk) disable iff (rst)
    irq_take && !$past(rst) && $past(ie_q[SRC_TMR] && irq_q[SRC_TMR])
      |-> irq_vec == 12'h002);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> !irq_take);
endmodule

// File: tb/tb_intc_core.sv
module tb_intc_core;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_done = 0, wr_en = 0, wr_sel = 0, tmr_evt = 0, port_evt = 0;
  logic [3:0] wr_data = '0;
  logic [11:0] cur_pc = '0;
  logic cur_cy = 0, call_push = 0, ret_pop = 0, ret_cy_mode = 0;
  logic [3:0] ie_q, irq_q;
  logic irq_take, push_req, ret_valid, ret_cy, ret_cy_ld;
  logic [11:0] irq_vec, ret_pc;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [1:0] m_ie, m_rq;
  int m_cnt;
  logic m_take, m_push, m_rv, m_rchk, m_rld;
  logic [11:0] m_vec;
  logic [12:0] m_stk [4];
  logic [12:0] m_rdat;
  int m_depth;

  always #4 clk = ~clk;

  intc_core dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] vec_of(input logic [1:0] hit);
    return hit[0] ? 12'h002 : 12'h004;
  endfunction

  task automatic model_reset();
    m_ie = 0; m_rq = 0; m_cnt = 0; m_take = 0; m_push = 0; m_rv = 0;
    m_rchk = 0; m_rld = 0; m_vec = 0; m_depth = 0;
  endtask

  task automatic model_step();
    logic pend, take;
    logic [1:0] hit;
    hit  = m_ie & m_rq;
    pend = |hit;
    take = pend && (m_cnt == 2);
    if (take) m_vec = vec_of(hit);
    m_take = take;
    m_cnt = (take || !pend) ? 0 : ((instr_done && m_cnt < 2) ? m_cnt + 1 : m_cnt);
    m_rq = ((wr_en && wr_sel) ? wr_data[1:0] : m_rq) | {port_evt, tmr_evt};
    m_ie = take ? 2'b00 : ((wr_en && !wr_sel) ? wr_data[1:0] : m_ie);
    m_push = take || call_push;
    m_rv = 0;
    if (m_push) begin
      for (int i = 3; i > 0; i--) m_stk[i] = m_stk[i-1];
      m_stk[0] = {cur_cy, cur_pc};
      if (m_depth < 4) m_depth++;
    end else if (ret_pop) begin
      m_rv = 1; m_rld = ret_cy_mode;
      m_rchk = (m_depth > 0);
      if (m_depth > 0) begin
        m_rdat = m_stk[0];
        for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i+1];
        m_depth--;
      end
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " R2 ie_q"}, ie_q, {2'b00, m_ie});
    chk({tag, " R2 R3 irq_q"}, irq_q, {2'b00, m_rq});
    chk({tag, " R5 R6 irq_take"}, irq_take, m_take);
    chk({tag, " R7 irq_vec"}, irq_vec, m_vec);
    chk({tag, " R9 push_req"}, push_req, m_push);
    chk({tag, " R10 ret_valid"}, ret_valid, m_rv);
    if (m_rv) chk({tag, " R10 ret_cy_ld"}, ret_cy_ld, m_rld);
    if (m_rv && m_rchk) chk({tag, " R10 R11 ret entry"}, {ret_cy, ret_pc}, m_rdat);
  endtask

  // drive one cycle: flags = {idn, we, sel, te, pe, call, pop, mode}
  task automatic step(input string tag, input logic [7:0] f,
                      input logic [3:0] wd = 4'h0, input logic [11:0] pc = 12'h0,
                      input logic cy = 1'b0);
    {instr_done, wr_en, wr_sel, tmr_evt, port_evt, call_push, ret_pop, ret_cy_mode} = f;
    wr_data = wd; cur_pc = pc; cur_cy = cy;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [7:0] IDLE = 8'h00, IDN = 8'h80, WEN = 8'hC0, WRQ = 8'hE0,
                         TEV = 8'h10, PEV = 8'h08, CALL = 8'h04, POPI = 8'h03,
                         POPC = 8'h02;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 ie_q", ie_q, 0);
    chk("R1 irq_q", irq_q, 0);
    chk("R1 irq_take", irq_take, 0);
    chk("R1 irq_vec", irq_vec, 0);
    chk("R1 push_req", push_req, 0);
    chk("R1 ret_valid", ret_valid, 0);

    // R2 upper bits read zero
    step("R2 wr en", WEN, 4'hF);
    step("R2 wr rq", WRQ, 4'hC);
    step("R2 clr en", WEN, 4'h0);
    // R3 hardware set beats software clear
    step("R3 set", TEV);
    step("R3 collide", WRQ | TEV, 4'h0);
    step("R3 collide port", WRQ | PEV, 4'h0);
    step("R3 clear", WRQ, 4'h0);

    // R5 R8 R9: request pending, enable written, two instructions, accept
    step("R5 req", TEV);
    step("R4 not enabled", IDN);
    step("R5 enable", WEN, 4'h1);
    step("R5 I1", IDN);
    step("R5 gap", IDLE);
    step("R5 I2", IDN);
    step("R5 R8 accept", IDLE, 4'h0, 12'h123, 1'b1);
    step("R5 R9 strobe", WEN, 4'h3);
    step("R8 after", IDLE);

    // R6 cancel on I1
    step("R6 clr", WRQ, 4'h0);
    step("R6 setup", WEN, 4'h2);
    step("R6 req", PEV);
    step("R6 I1 clears en", WEN, 4'h0);
    step("R6 I2", IDN);
    repeat (3) step("R6 none", IDN);
    // R6 cancel on I2
    step("R6 en", WEN, 4'h2);
    step("R6 I1", IDN);
    step("R6 I2 clears rq", WRQ, 4'h0);
    repeat (3) step("R6 none2", IDN);
    // R6 clear then re-set back to back
    step("R6 rq", WRQ, 4'h2);
    step("R6 I1", IDN);
    step("R6 drop", WRQ, 4'h0);
    step("R6 reset", WRQ, 4'h2);
    repeat (4) step("R6 restart", IDN, 4'h0, 12'h3A0);

    // R7 priority: both pending
    step("R7 rq both", WRQ, 4'h3);
    step("R7 en both", WEN, 4'h3);
    repeat (4) step("R7 prio", IDN, 4'h0, 12'h055);
    step("R7 en port only", WRQ, 4'h2);
    step("R7 en", WEN, 4'h2);
    repeat (4) step("R7 port vec", IDN, 4'h0, 12'h066);

    // R10 pops with both carry modes
    step("R10 pop irq", POPI);
    step("R10 pop const", POPC);
    step("R10 idle", IDLE);

    // R11 overflow: five calls, four pops
    step("R11 clr", WEN, 4'h0);
    for (int k = 1; k <= 5; k++) step("R11 call", CALL, 4'h0, 12'(k * 17), k[0]);
    for (int k = 0; k < 4; k++) step("R11 pop", POPI);
    step("R11 idle", IDLE);

    // constrained random
    seed = 32'h1BADC0DE;
    void'($urandom(seed));
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] f;
      f = '0;
      f[7] = ($urandom % 2) == 0;
      f[6] = ($urandom % 8) == 0;
      f[5] = $urandom % 2;
      f[4] = ($urandom % 12) == 0;
      f[3] = ($urandom % 12) == 0;
      f[2] = ($urandom % 20) == 0;
      f[1] = ($urandom % 10) == 0;
      f[0] = $urandom % 2;
      step("RND", f, 4'($urandom), 12'($urandom), 1'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule